// File: doc/BRIEF.md
# Basic up-counting interval timer with deferred clock divider

The block is a small timer peripheral driven through a single-port register bus. A 16-bit divider turns the input clock into count ticks, and a 16-bit counter climbs on each tick until it reaches a reload limit. It then returns to zero and raises an update event. Software can also raise an update event on demand. An update event is the only moment when the divider value written by software becomes active. It is optionally also the moment when a new reload limit becomes active.

After reset the active divider is zero. A timer that is started without first forcing an update therefore runs its first period at the full input clock rate. Software normally programs the divider and the reload value, selects the overflow-only reporting mode and forces one update. It then clears the flag, enables the interrupt and starts the counter. A debug-freeze input stops counting while register contents stay readable. The interrupt output is the registered AND of the update flag and its enable.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, enable, flag, count and divider registers read 0, the reload register reads 16'hFFFF, the trigger address reads 0 and `irq` is 0.
- R2: The register map is: address 0 control (bit0 run, bit1 buffered reload, bit2 overflow-only reporting), 1 interrupt enable (bit0), 2 update flag (bit0), 3 update trigger, 4 count, 5 divider, 6 reload. Before any update event the active divider is 0. A counter started from 0 with reload value N therefore sets the flag N+1 clocks after the run bit is written.
- R3: A divider write changes the stored value at once. The active divider and the divider phase change only at an update event: the divider is loaded and the phase is cleared. With active divider P, the counter advances once every P+1 clocks.
- R4: While running, the counter increments on each tick. A tick while the count equals the effective reload value returns the count to 0 and is an update event.
- R5: With control bit1 = 0 the effective reload value is the last value written to address 6, starting the clock after the write. With bit1 = 1 it is a shadow copy that takes the written value only at an update event.
- R6: A counter overflow always sets the flag. A software-triggered update sets the flag only when control bit2 = 0.
- R7: Writing a word with bit0 = 1 to address 3 is an update event. It clears the count and the divider phase and loads the divider and reload shadows. Address 3 always reads 0.
- R8: Writing a word with bit0 = 0 to address 2 clears the flag. Writing bit0 = 1 leaves it unchanged. If an overflow falls in the same clock as a clearing write, the flag ends up set.
- R9: `irq` equals the AND of the flag and the interrupt enable as they stood one clock earlier.
- R10: While `freeze` is 1, the count and the divider phase do not change unless software writes them.
- R11: A write to address 4 loads the count on that clock and is not an update event: it does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Debug halt of counter and divider |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Update interrupt request |

## Verification
Two functions can meet on a single clock edge: a software flag clear and a hardware overflow that sets the flag. The bench watches its own reference model. When the model shows the count at the limit with a tick due, the bench issues the clearing write on exactly that edge. The flag must then read back as set. Similar collisions are also exercised: a count write racing a tick, a reload write landing beside an update, and a divider write waiting for its update. The model is compared against the count, the read data and `irq` on every clock.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_IEN    = 3'd1,
        A_FLAG   = 3'd2,
        A_FORCE  = 3'd3,
        A_COUNT  = 3'd4,
        A_DIV    = 3'd5,
        A_RELOAD = 3'd6,
        A_NONE   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic ovf_only;
        logic buffered;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         upd,
    input  logic [W-1:0] div_pre,
    output logic         tick,
    output logic [W-1:0] div_act
);
    typedef struct packed {
        logic [W-1:0] div;
        logic [W-1:0] phase;
    } ps_t;

    ps_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && (s_q.phase == s_q.div);
        if (upd) begin
            s_d.div   = div_pre;
            s_d.phase = '0;
        end else if (run) begin
            s_d.phase = tick ? '0 : s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign div_act = s_q.div;
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         force_upd,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        ovf   = tick && (cnt_q == limit);
        if (force_upd)  cnt_d = '0;
        else if (ld)    cnt_d = ld_val;
        else if (tick)  cnt_d = ovf ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int          W          = 16,
    parameter logic [15:0] RELOAD_RST = 16'hFFFF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              freeze,
    input  logic                              wr_en,
    input  logic [tick_timer_pkg::ADDR_W-1:0] addr,
    input  logic [W-1:0]                      wr_data,
    output logic [W-1:0]                      rd_data,
    output logic                              irq
);
    import tick_timer_pkg::*;

    typedef struct packed {
        ctrl_t        ctrl;
        logic         ien;
        logic         flag;
        logic [W-1:0] div_pre;
        logic [W-1:0] rel_pre;
        logic [W-1:0] rel_sh;
        logic         irq;
    } regs_t;

    regs_t s_d, s_q;

    reg_addr_e    a;
    logic         wr_ctrl, wr_ien, wr_flag, wr_cnt, wr_div, wr_rel;
    logic         force_upd, run, tick, ovf, upd;
    logic [W-1:0] limit, cnt, div_act;
    logic         flag_q, ien_q, src_q;

    assign a         = reg_addr_e'(addr);
    assign wr_ctrl   = wr_en && (a == A_CTRL);
    assign wr_ien    = wr_en && (a == A_IEN);
    assign wr_flag   = wr_en && (a == A_FLAG);
    assign wr_cnt    = wr_en && (a == A_COUNT);
    assign wr_div    = wr_en && (a == A_DIV);
    assign wr_rel    = wr_en && (a == A_RELOAD);
    assign force_upd = wr_en && (a == A_FORCE) && wr_data[0];
    assign run       = s_q.ctrl.run && !freeze;
    assign limit     = s_q.ctrl.buffered ? s_q.rel_sh : s_q.rel_pre;
    assign upd       = ovf || force_upd;
    assign flag_q    = s_q.flag;
    assign ien_q     = s_q.ien;
    assign src_q     = s_q.ctrl.ovf_only;

    tt_prescaler #(.W(W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .upd     (upd),
        .div_pre (s_q.div_pre),
        .tick    (tick),
        .div_act (div_act)
    );

    tt_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .force_upd (force_upd),
        .ld        (wr_cnt),
        .ld_val    (wr_data),
        .limit     (limit),
        .cnt       (cnt),
        .ovf       (ovf)
    );

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.ctrl.run      = wr_data[0];
            s_d.ctrl.buffered = wr_data[1];
            s_d.ctrl.ovf_only = wr_data[2];
        end
        if (wr_ien) s_d.ien     = wr_data[0];
        if (wr_div) s_d.div_pre = wr_data;
        if (wr_rel) s_d.rel_pre = wr_data;
        if (upd)    s_d.rel_sh  = s_q.rel_pre;
        if (ovf || (force_upd && !s_q.ctrl.ovf_only)) s_d.flag = 1'b1;
        else if (wr_flag && !wr_data[0])              s_d.flag = 1'b0;
        s_d.irq = s_q.flag && s_q.ien;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.rel_pre <= W'(RELOAD_RST);
            s_q.rel_sh  <= W'(RELOAD_RST);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (a)
            A_CTRL: begin
                rd_data[0] = s_q.ctrl.run;
                rd_data[1] = s_q.ctrl.buffered;
                rd_data[2] = s_q.ctrl.ovf_only;
            end
            A_IEN:    rd_data[0] = s_q.ien;
            A_FLAG:   rd_data[0] = s_q.flag;
            A_COUNT:  rd_data    = cnt;
            A_DIV:    rd_data    = s_q.div_pre;
            A_RELOAD: rd_data    = s_q.rel_pre;
            default:  rd_data    = '0;
        endcase
    end

    assign irq = s_q.irq;
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         freeze,
    input logic         irq,
    input logic         flag_q,
    input logic         ien_q,
    input logic         src_q,
    input logic         ovf,
    input logic         upd,
    input logic         force_upd,
    input logic         ld,
    input logic [W-1:0] ld_val,
    input logic [W-1:0] cnt,
    input logic [W-1:0] div_act
);
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !ld |=> cnt == '0);

    p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(div_act));

    p_force_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd && src_q && !ovf && !flag_q |=> !flag_q);

    p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(flag_q && ien_q));

    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        freeze && !ld && !force_upd |=> $stable(cnt));

    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld && !force_upd |=> cnt == $past(ld_val));
endmodule

bind tick_timer tick_timer_checker #(.W(W)) u_tick_timer_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .irq       (irq),
    .flag_q    (flag_q),
    .ien_q     (ien_q),
    .src_q     (src_q),
    .ovf       (ovf),
    .upd       (upd),
    .force_upd (force_upd),
    .ld        (wr_cnt),
    .ld_val    (wr_data),
    .cnt       (cnt),
    .div_act   (div_act)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // reference model state
    int m_run, m_buf, m_src, m_ien, m_flag, m_irq;
    int m_div_pre, m_div, m_phase, m_cnt, m_rel_pre, m_rel_sh;

    always #10 clk = ~clk;

    tick_timer u_tick_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .freeze  (freeze),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    function automatic int model_read(input int a);
        case (a)
            0: return m_run + 2 * m_buf + 4 * m_src;
            1: return m_ien;
            2: return m_flag;
            4: return m_cnt;
            5: return m_div_pre;
            6: return m_rel_pre;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_buf = 0; m_src = 0; m_ien = 0; m_flag = 0; m_irq = 0;
            m_div_pre = 0; m_div = 0; m_phase = 0; m_cnt = 0;
            m_rel_pre = 16'hFFFF; m_rel_sh = 16'hFFFF;
        end else begin
            int  d, lim, n_flag;
            bit  running, tick, ovf, frc, upd;
            d       = int'(wr_data);
            frc     = wr_en && addr == 3 && wr_data[0];
            lim     = m_buf ? m_rel_sh : m_rel_pre;
            running = m_run != 0 && !freeze;
            tick    = running && m_phase == m_div;
            ovf     = tick && m_cnt == lim;
            upd     = ovf || frc;
            m_irq   = (m_flag != 0 && m_ien != 0) ? 1 : 0;
            n_flag  = m_flag;
            if (ovf || (frc && m_src == 0)) n_flag = 1;
            else if (wr_en && addr == 2 && !wr_data[0]) n_flag = 0;
            if (frc) m_cnt = 0;
            else if (wr_en && addr == 4) m_cnt = d;
            else if (tick) m_cnt = ovf ? 0 : m_cnt + 1;
            if (upd) begin
                m_div = m_div_pre; m_phase = 0; m_rel_sh = m_rel_pre;
            end else if (running) begin
                m_phase = tick ? 0 : m_phase + 1;
            end
            m_flag = n_flag;
            if (wr_en && addr == 0) begin
                m_run = d % 2; m_buf = (d / 2) % 2; m_src = (d / 4) % 2;
            end
            if (wr_en && addr == 1) m_ien = d % 2;
            if (wr_en && addr == 5) m_div_pre = d;
            if (wr_en && addr == 6) m_rel_pre = d;
        end
    end

    task automatic chk(input int act, input int exp, input string tag, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk(int'(irq), m_irq, "R9", "irq vs model");
            chk(int'(rd_data), model_read(int'(addr)), cur_tag, "read data vs model");
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v, c0;
        cyc(3);
        rst_n = 1'b1;
        // R1 reset values
        for (int i = 0; i < 8; i++) begin
            peek(3'(i), v);
            chk(v, (i == 6) ? 16'hFFFF : 0, "R1", "reset read");
        end
        chk(int'(irq), 0, "R1", "reset irq");

        // R2 first period at undivided clock
        cur_tag = "R2";
        wr(3'd6, 16'd4);
        wr(3'd5, 16'd9);
        wr(3'd0, 16'd1);
        cyc(4);
        peek(3'd2, v); chk(v, 0, "R2", "flag before ARR+1 clocks");
        cyc(1);
        peek(3'd2, v); chk(v, 1, "R2", "flag at ARR+1 clocks");
        peek(3'd4, v); chk(v, 0, "R4", "count wrapped to 0");

        // R3 divider now active: next overflow 50 clocks after the update
        cur_tag = "R3";
        wr(3'd2, 16'd0);
        peek(3'd2, v); chk(v, 0, "R8", "flag cleared by 0 write");
        cyc(48);
        peek(3'd2, v); chk(v, 0, "R3", "flag before divided period");
        cyc(1);
        peek(3'd2, v); chk(v, 1, "R3", "flag at divided period");

        // R9 interrupt output
        cur_tag = "R9";
        wr(3'd1, 16'd1);
        chk(int'(irq), 0, "R9", "irq one clock after enable write");
        cyc(1);
        chk(int'(irq), 1, "R9", "irq two clocks after enable write");

        // R8 write 1 no effect, write 0 clears
        cur_tag = "R8";
        wr(3'd2, 16'd1);
        peek(3'd2, v); chk(v, 1, "R8", "flag after write 1");
        wr(3'd2, 16'd0);
        peek(3'd2, v); chk(v, 0, "R8", "flag after write 0");
        chk(int'(irq), 1, "R9", "irq still high one clock after clear");
        cyc(1);
        chk(int'(irq), 0, "R9", "irq low after clear");
        wr(3'd1, 16'd0);

        // R10 freeze
        cur_tag = "R10";
        freeze = 1'b1;
        peek(3'd4, c0);
        cyc(30);
        peek(3'd4, v); chk(v, c0, "R10", "count frozen");
        freeze = 1'b0;
        cyc(2);

        // R11 count write
        cur_tag = "R11";
        wr(3'd4, 16'd3);
        peek(3'd4, v); chk(v, 3, "R11", "count loaded");
        peek(3'd2, v); chk(v, 0, "R11", "no flag from count write");

        // R6/R7 forced update
        cur_tag = "R7";
        wr(3'd0, 16'd5);
        wr(3'd3, 16'd1);
        peek(3'd4, v); chk(v, 0, "R7", "count cleared by trigger");
        peek(3'd2, v); chk(v, 0, "R6", "overflow-only: trigger sets no flag");
        peek(3'd3, v); chk(v, 0, "R7", "trigger address reads 0");
        cur_tag = "R6";
        wr(3'd0, 16'd1);
        wr(3'd3, 16'd1);
        peek(3'd2, v); chk(v, 1, "R6", "trigger sets flag when bit2=0");
        peek(3'd4, v); chk(v, 0, "R7", "count cleared by second trigger");

        // R5 buffered then unbuffered reload
        cur_tag = "R5";
        wr(3'd2, 16'd0);
        wr(3'd0, 16'd0);
        wr(3'd5, 16'd0);
        wr(3'd6, 16'd2);
        wr(3'd3, 16'd1);
        wr(3'd0, 16'd3);
        wr(3'd6, 16'd6);
        peek(3'd4, v); chk(v, 1, "R5", "buffered count step 1");
        cyc(1);
        peek(3'd4, v); chk(v, 2, "R5", "buffered count at shadow limit");
        cyc(1);
        peek(3'd4, v); chk(v, 0, "R5", "buffered wraps at shadow value");
        wr(3'd0, 16'd1);
        wr(3'd6, 16'd3);
        peek(3'd4, v); chk(v, 2, "R5", "unbuffered count step");
        cyc(1);
        peek(3'd4, v); chk(v, 3, "R5", "unbuffered count at new limit");
        cyc(1);
        peek(3'd4, v); chk(v, 0, "R5", "unbuffered wraps at new value at once");

        // R8 collision: clear write on the overflow edge
        cur_tag = "R8";
        wr(3'd2, 16'd0);
        while (m_cnt != 3) cyc(1);
        wr(3'd2, 16'd0);
        peek(3'd2, v); chk(v, 1, "R8", "hardware set wins over clear");
        cur_tag = "R4";
        cyc(20);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule